// File: doc/BRIEF.md
# Timer Compare-Match Output Unit

This block couples a free-running 16-bit up-counter to a 16-bit compare register. On every clock the two values are compared. When they first become equal, the block carries out the action picked by a 4-bit mode field. It can drive an output latch high or low. It can raise only the match interrupt flag. It can also fire a special event trigger, which returns the counter to zero, so the compare register serves as a programmable period.

The special event trigger can also send a one-cycle start-conversion strobe to an analog converter. The strobe is sent only while the converter-enable input is high. A counter reset caused by the trigger never counts as an overflow, so the overflow flag is set only by a natural rollover.

Software writes the compare value and the mode through separate write strobes. The output latch reaches the pin only while the direction input selects output.

Top module: `cmp_match_unit`

## Requirements
- R1: After reset the counter is 0, the output latch is low, the pin is low, and the match flag, overflow flag and conversion strobe are all 0.
- R2: While `cnt_en` is high the counter advances by one per clock. A match is recognised only on the first clock on which the counter equals the compare value. A stalled counter that stays equal does not match again.
- R3: Mode 4'b1000 drives the output latch high on a match. Mode 4'b1001 drives it low on a match. In both cases the new level is visible on the clock after the matching one.
- R4: In mode 4'b1010 a match sets only the match flag. The output latch keeps its level and the counter keeps counting.
- R5: Any match in modes 4'b1000 to 4'b1011 sets the match flag. The flag stays set until `flag_clr` is applied. A set and a clear in the same clock leave the flag set. Modes 4'b0000 and 4'b1100 to 4'b1111, as well as 4'b0001 to 4'b0111, take no action and do not set the flag.
- R6: Writing 4'b0000 to the mode register forces the output latch low on the next clock.
- R7: In mode 4'b1011 a match loads the counter with 0 on the next clock, which gives a period of compare+1 counts. The match also pulses `conv_start` high for exactly that one clock, but only if `adc_en` was high.
- R8: The overflow flag is set only when the counter rolls over naturally from 0xFFFF to 0x0000. A reset by the special event trigger at 0xFFFF leaves it clear. `ovf_clr` clears it.
- R9: `pin_oe` follows `dir_out`. `pin_o` shows the output latch only while `dir_out` is 1, and is 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmp_we | input | 1 | Write strobe for the compare value |
| cmp_wdata | input | 16 | New compare value |
| mode_we | input | 1 | Write strobe for the mode field |
| mode_wdata | input | 4 | New mode value |
| cnt_en | input | 1 | Counter run enable |
| adc_en | input | 1 | Converter enabled; gates the conversion strobe |
| dir_out | input | 1 | 1 selects the pin as output |
| flag_clr | input | 1 | Clears the match flag |
| ovf_clr | input | 1 | Clears the overflow flag |
| cnt_o | output | 16 | Current counter value |
| pin_o | output | 1 | Compare output pin level |
| pin_oe | output | 1 | Pin output enable |
| match_flag | output | 1 | Sticky match interrupt flag |
| ovf_flag | output | 1 | Sticky counter overflow flag |
| conv_start | output | 1 | One-cycle start-conversion strobe |

## Verification
The compare function is tested with four patterns:
- A running counter that reaches the compare value.
- A counter halted exactly on the compare value, which separates edge-detected matching from level matching.
- A compare value reached after the mode has been changed, which separates the set, clear, interrupt-only and no-action modes by their effect on the pin, the flag and the counter.
- Special event runs with the converter enabled and disabled, which show the period length and whether the strobe is gated.

Two full-range runs compare a natural rollover with a trigger at 0xFFFF. They show whether the overflow flag reacts to the counter's source of zero and not merely to its value.

// File: rtl/cmp_match_unit.sv
module cmp_match_unit #(
  parameter int CW = 16,
  parameter int MW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmp_we,
  input  logic [CW-1:0] cmp_wdata,
  input  logic          mode_we,
  input  logic [MW-1:0] mode_wdata,
  input  logic          cnt_en,
  input  logic          adc_en,
  input  logic          dir_out,
  input  logic          flag_clr,
  input  logic          ovf_clr,
  output logic [CW-1:0] cnt_o,
  output logic          pin_o,
  output logic          pin_oe,
  output logic          match_flag,
  output logic          ovf_flag,
  output logic          conv_start
);
  localparam logic [MW-1:0] M_OFF = '0;
  localparam logic [MW-1:0] M_SET = MW'(4'b1000);
  localparam logic [MW-1:0] M_CLR = MW'(4'b1001);
  localparam logic [MW-1:0] M_SWI = MW'(4'b1010);
  localparam logic [MW-1:0] M_SEV = MW'(4'b1011);
  localparam logic [CW-1:0] CNT_MAX = '1;

  logic [CW-1:0] cnt, cmp;
  logic [MW-1:0] mode;
  logic          eq_q, out_latch;

  wire eq       = (cnt == cmp);
  wire match_ev = eq && !eq_q;
  wire act_mode = (mode == M_SET) || (mode == M_CLR) || (mode == M_SWI) || (mode == M_SEV);
  wire trig     = match_ev && (mode == M_SEV);
  wire wrap     = cnt_en && !trig && (cnt == CNT_MAX);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt  <= '0;
      cmp  <= '0;
      mode <= M_OFF;
      eq_q <= 1'b0;
    end else begin
      eq_q <= eq;
      if (cmp_we)  cmp  <= cmp_wdata;
      if (mode_we) mode <= mode_wdata;
      if (trig)        cnt <= '0;
      else if (cnt_en) cnt <= cnt + CW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      out_latch <= 1'b0;
    else if (mode_we && mode_wdata == M_OFF)
      out_latch <= 1'b0;
    else if (match_ev && mode == M_SET)
      out_latch <= 1'b1;
    else if (match_ev && mode == M_CLR)
      out_latch <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      match_flag <= 1'b0;
      ovf_flag   <= 1'b0;
      conv_start <= 1'b0;
    end else begin
      if (match_ev && act_mode) match_flag <= 1'b1;
      else if (flag_clr)        match_flag <= 1'b0;
      if (wrap)         ovf_flag <= 1'b1;
      else if (ovf_clr) ovf_flag <= 1'b0;
      conv_start <= trig && adc_en;
    end
  end

  assign cnt_o  = cnt;
  assign pin_oe = dir_out;
  assign pin_o  = dir_out & out_latch;

  // R5
  flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (match_ev && act_mode) |=> match_flag);
  // R2
  no_retrig_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eq && !cmp_we && !cnt_en && !trig) |=> !match_ev);
  // R4
  swi_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (match_ev && mode == M_SWI && !mode_we) |=> $stable(out_latch));
  // R6
  off_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_we && mode_wdata == M_OFF) |=> !out_latch);
  // R7
  sev_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trig |=> (cnt == '0));
  // R8
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (trig && !ovf_flag) |=> !ovf_flag);
  // R9
  pin_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dir_out |-> !pin_o);
endmodule

// File: tb/tb_cmp_match_unit.sv
module tb_cmp_match_unit;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic cmp_we = 0, mode_we = 0, cnt_en = 0, adc_en = 0, dir_out = 1;
  logic flag_clr = 0, ovf_clr = 0;
  logic [15:0] cmp_wdata = 0;
  logic [3:0]  mode_wdata = 0;
  logic [15:0] cnt_o;
  logic pin_o, pin_oe, match_flag, ovf_flag, conv_start;
  int n_run = 0, n_fail = 0;

  cmp_match_unit dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input longint act, input longint exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; cmp_we = 0; mode_we = 0; cnt_en = 0; adc_en = 0;
    dir_out = 1; flag_clr = 0; ovf_clr = 0;
    @(negedge clk); @(negedge clk);
    rst_n = 1;
  endtask

  task automatic wr_cmp(input logic [15:0] v);
    cmp_wdata = v; cmp_we = 1;
    @(negedge clk); cmp_we = 0;
  endtask

  task automatic wr_mode(input logic [3:0] m);
    mode_wdata = m; mode_we = 1;
    @(negedge clk); mode_we = 0;
  endtask

  task automatic run(input int n);
    cnt_en = 1;
    repeat (n) @(posedge clk);
    @(negedge clk); cnt_en = 0;
  endtask

  task automatic pulse_clr();
    flag_clr = 1; @(negedge clk); flag_clr = 0;
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 cnt", cnt_o, 0);
    chk("R1 pin", pin_o, 0);
    chk("R1 flags", {match_flag, ovf_flag, conv_start}, 0);
  endtask

  task automatic t_set_and_priority();
    do_reset();
    wr_mode(4'b1000); wr_cmp(16'd5);
    cnt_en = 1;
    repeat (5) @(posedge clk);
    @(negedge clk);
    chk("R2 cnt at match", cnt_o, 5);
    chk("R3 pin before match edge", pin_o, 0);
    flag_clr = 1;
    @(negedge clk);
    flag_clr = 0; cnt_en = 0;
    chk("R3 set on match", pin_o, 1);
    chk("R5 set wins over clear", match_flag, 1);
    pulse_clr();
    chk("R5 clear", match_flag, 0);
  endtask

  task automatic t_stall();
    do_reset();
    wr_mode(4'b1000); wr_cmp(16'd3);
    run(3);
    chk("R2 stalled at compare", cnt_o, 3);
    @(negedge clk);
    chk("R2 match on stall", match_flag, 1);
    pulse_clr();
    repeat (5) @(negedge clk);
    chk("R2 no retrigger", match_flag, 0);
  endtask

  task automatic t_clear_mode();
    do_reset();
    wr_mode(4'b1000); wr_cmp(16'd2);
    run(3);
    chk("R3 latch high", pin_o, 1);
    wr_mode(4'b1001); wr_cmp(16'd6);
    run(3);
    chk("R3 before clear", pin_o, 1);
    run(1);
    chk("R3 clear on match", pin_o, 0);
  endtask

  task automatic t_swi_and_off();
    do_reset();
    wr_mode(4'b1000); wr_cmp(16'd2);
    run(3);
    pulse_clr();
    wr_mode(4'b1010); wr_cmp(16'd5);
    run(3);
    chk("R4 pin unchanged", pin_o, 1);
    chk("R4 flag set", match_flag, 1);
    chk("R4 counter keeps going", cnt_o, 6);
    pulse_clr();
    wr_mode(4'b1100); wr_cmp(16'd8);
    run(3);
    chk("R5 undefined mode no flag", match_flag, 0);
    chk("R5 undefined mode pin", pin_o, 1);
    dir_out = 0;
    @(negedge clk);
    chk("R9 pin gated", pin_o, 0);
    chk("R9 oe low", pin_oe, 0);
    dir_out = 1;
    @(negedge clk);
    chk("R9 pin shown", pin_o, 1);
    wr_mode(4'b0000);
    chk("R6 off forces low", pin_o, 0);
  endtask

  task automatic t_special(input logic adc);
    do_reset();
    adc_en = adc;
    wr_mode(4'b1011); wr_cmp(16'd4);
    cnt_en = 1;
    repeat (5) @(posedge clk);
    @(negedge clk);
    chk("R7 counter reset", cnt_o, 0);
    chk("R7 strobe", conv_start, adc);
    chk("R7 flag", match_flag, 1);
    @(negedge clk);
    chk("R7 strobe one cycle", conv_start, 0);
    chk("R7 count resumes", cnt_o, 1);
    repeat (4) @(negedge clk);
    chk("R7 period", cnt_o, 0);
    cnt_en = 0;
  endtask

  task automatic t_overflow();
    do_reset();
    run(65536);
    chk("R8 natural wrap cnt", cnt_o, 0);
    chk("R8 natural wrap flag", ovf_flag, 1);
    ovf_clr = 1; @(negedge clk); ovf_clr = 0;
    chk("R8 clear", ovf_flag, 0);
    do_reset();
    wr_mode(4'b1011); wr_cmp(16'hFFFF);
    run(65536);
    chk("R8 trigger cnt", cnt_o, 0);
    chk("R8 trigger no overflow", ovf_flag, 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_set_and_priority();
    t_stall();
    t_clear_mode();
    t_swi_and_off();
    t_special(1'b1);
    t_special(1'b0);
    t_overflow();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule